// File: doc/BRIEF.md
# Rotate-Extend-Accumulate Instruction Unit

This unit decodes and executes one instruction of a 32-bit processor. The instruction takes a second source register value and rotates it right by a whole number of bytes. It takes the low 16 bits of the rotated value as a signed number, widens that to 32 bits and adds it to a first source register value. Each cycle the unit accepts one instruction word, a format select, the current N, Z, C and V flags, and the two source operands.

The instruction can arrive in two formats. In the fixed-width format it is a single 32-bit word that carries a condition field. In the compact format it is two 16-bit halfwords, always executed, presented as one 32-bit bus with the first halfword in the upper half. The unit checks every fixed bit of the selected format and pulls out the register and rotate fields. It evaluates the condition and, one cycle later, presents a registered result. Alongside the result it gives the destination index, the two source indices, a write-enable, and a not-this-instruction indication. The flags it presents are a registered copy of the flags it received.

Top module: `rea_top`

## Requirements
- R1: The second source is rotated right by 8 times the 2-bit rotate field, giving 0, 8, 16 or 24 bits, before anything else is done with it.
- R2: Bits [15:0] of the rotated value are sign-extended to 32 bits, with bit 15 copied into bits [31:16].
- R3: `result` equals `srcN` plus the sign-extended value, modulo 2^32. It appears one cycle after the instruction is accepted.
- R4: `flagsOut` (N at bit 3, Z bit 2, C bit 1, V bit 0) equals the `flagsIn` that came with the instruction. Carry-out or signed overflow of the add never changes it.
- R5: With `isCompact`=0 the word must match 0x06B00070 under mask 0x0FF003F0. The fields are condition [31:28], first source index [19:16], destination [15:12], rotate [11:10] and second source index [3:0].
- R6: With `isCompact`=1 the bus must match 0xFA00F080 under mask 0xFFF0F0C0. The fields are first source index [19:16], destination [11:8], rotate [5:4] and second source index [3:0].
- R7: In the fixed-width format, `writeEn` is set only when the condition passes. The codes 0..14 are, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), and always. A failing condition gives `outValid`=1, `writeEn`=0 and `illegal`=0.
- R8: Condition code 1111 in the fixed-width format is not this instruction. It gives `illegal`=1 and `writeEn`=0.
- R9: In the compact format, execution does not depend on the flags. A matching bus always gives `writeEn`=1.
- R10: A wrong value in any fixed bit of the selected format gives `illegal`=1 and `writeEn`=0.
- R11: `outValid` equals `inValid` delayed by one cycle. A cycle with `inValid`=0 gives `writeEn`=0 and `illegal`=0 and leaves the data outputs unchanged.
- R12: A synchronous active-high `rst` clears `outValid`, `writeEn`, `illegal` and all data outputs to zero.
- R13: `dstIdx`, `rnIdx` and `rmIdx` present the register fields decoded for the selected format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction presented this cycle |
| isCompact | input | 1 | 1 selects the two-halfword format, 0 the 32-bit word format |
| instrWord | input | 32 | Instruction bits (compact: first halfword in [31:16]) |
| flagsIn | input | 4 | Current N, Z, C, V flags |
| srcN | input | 32 | First source (accumulator) value |
| srcM | input | 32 | Second source value, rotated and extended |
| outValid | output | 1 | Registered outputs belong to an accepted instruction |
| result | output | 32 | Sum of first source and extended halfword |
| dstIdx | output | 4 | Destination register index |
| rnIdx | output | 4 | First source register index |
| rmIdx | output | 4 | Second source register index |
| writeEn | output | 1 | Destination should be written |
| illegal | output | 1 | Word is not this instruction |
| flagsOut | output | 4 | Flags passed through unchanged |

## Verification
The assertions rely on `isCompact` and `instrWord` being meaningful only in cycles with `inValid` high. They also assume the format select never calls for a decode of the other format's bits. For this reason the checks on decode outcomes are all gated by `inValid` and the format select. The stimulus supplies a full, known instruction in every valid cycle. It leaves gaps with `inValid` low only to exercise the hold behaviour. Corrupted words are produced by flipping exactly one fixed bit of a correctly encoded word, so every reachable outcome is a known legal or illegal case.

// File: rtl/rea_pkg.sv
package rea_pkg;

  localparam int IDX_W  = 4;
  localparam int ROT_W  = 2;
  localparam int COND_W = 4;
  localparam int INSN_W = 32;

  // Fixed-bit masks and required values for each format
  localparam logic [INSN_W-1:0] WORD_MASK = 32'h0FF0_03F0;
  localparam logic [INSN_W-1:0] WORD_BASE = 32'h06B0_0070;
  localparam logic [INSN_W-1:0] CMP_MASK  = 32'hFFF0_F0C0;
  localparam logic [INSN_W-1:0] CMP_BASE  = 32'hFA00_F080;

  // Field positions (low bit) for each format
  localparam int WORD_COND_LO = 28;
  localparam int WORD_RN_LO   = 16;
  localparam int WORD_RD_LO   = 12;
  localparam int WORD_ROT_LO  = 10;
  localparam int WORD_RM_LO   = 0;
  localparam int CMP_RN_LO    = 16;
  localparam int CMP_RD_LO    = 8;
  localparam int CMP_ROT_LO   = 4;
  localparam int CMP_RM_LO    = 0;

  typedef enum logic [COND_W-1:0] {
    COND_ZSET  = 4'h0, COND_ZCLR  = 4'h1, COND_CSET  = 4'h2, COND_CCLR  = 4'h3,
    COND_NSET  = 4'h4, COND_NCLR  = 4'h5, COND_VSET  = 4'h6, COND_VCLR  = 4'h7,
    COND_UHI   = 4'h8, COND_ULS   = 4'h9, COND_SGE   = 4'hA, COND_SLT   = 4'hB,
    COND_SGT   = 4'hC, COND_SLE   = 4'hD, COND_ANY   = 4'hE, COND_NONE  = 4'hF
  } condCode_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic             capture;
    logic             doWrite;
    logic             notOurs;
    logic [ROT_W-1:0] rotSel;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srcA;
    logic [IDX_W-1:0] srcB;
  } reaStrobes_t;

endpackage

// File: rtl/rea_cond.sv
module rea_cond
  import rea_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  logic [3:0]        nzcv,
  output logic              pass
);

  logic fN, fZ, fC, fV;
  condCode_t cc;

  always_comb begin
    fN = nzcv[3];
    fZ = nzcv[2];
    fC = nzcv[1];
    fV = nzcv[0];
    cc = condCode_t'(code);
    unique case (cc)
      COND_ZSET: pass = fZ;
      COND_ZCLR: pass = !fZ;
      COND_CSET: pass = fC;
      COND_CCLR: pass = !fC;
      COND_NSET: pass = fN;
      COND_NCLR: pass = !fN;
      COND_VSET: pass = fV;
      COND_VCLR: pass = !fV;
      COND_UHI:  pass = fC && !fZ;
      COND_ULS:  pass = !fC || fZ;
      COND_SGE:  pass = (fN == fV);
      COND_SLT:  pass = (fN != fV);
      COND_SGT:  pass = !fZ && (fN == fV);
      COND_SLE:  pass = fZ || (fN != fV);
      COND_ANY:  pass = 1'b1;
      default:   pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/rea_ctrl.sv
module rea_ctrl
  import rea_pkg::*;
(
  input  logic              inValid,
  input  logic              isCompact,
  input  logic [INSN_W-1:0] instrWord,
  input  logic [3:0]        flagsIn,
  output reaStrobes_t       strb
);

  logic              wordFixedOk;
  logic              cmpFixedOk;
  logic              condOk;
  logic              formatOk;
  logic              execOk;
  logic [COND_W-1:0] condField;

  assign condField = instrWord[WORD_COND_LO +: COND_W];

  rea_cond condEval_i (
    .code (condField),
    .nzcv (flagsIn),
    .pass (condOk)
  );

  always_comb begin
    wordFixedOk = ((instrWord & WORD_MASK) == WORD_BASE);
    cmpFixedOk  = ((instrWord & CMP_MASK) == CMP_BASE);

    if (isCompact) begin
      formatOk    = cmpFixedOk;
      execOk      = 1'b1;
      strb.rotSel = instrWord[CMP_ROT_LO +: ROT_W];
      strb.dst    = instrWord[CMP_RD_LO  +: IDX_W];
      strb.srcA   = instrWord[CMP_RN_LO  +: IDX_W];
      strb.srcB   = instrWord[CMP_RM_LO  +: IDX_W];
    end else begin
      formatOk    = wordFixedOk && (condField != COND_NONE);
      execOk      = condOk;
      strb.rotSel = instrWord[WORD_ROT_LO +: ROT_W];
      strb.dst    = instrWord[WORD_RD_LO  +: IDX_W];
      strb.srcA   = instrWord[WORD_RN_LO  +: IDX_W];
      strb.srcB   = instrWord[WORD_RM_LO  +: IDX_W];
    end

    strb.capture = inValid;
    strb.doWrite = inValid && formatOk && execOk;
    strb.notOurs = inValid && !formatOk;
  end

endmodule

// File: rtl/rea_dpath.sv
module rea_dpath
  import rea_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ROT_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  reaStrobes_t       strb,
  input  logic [DATA_W-1:0] srcN,
  input  logic [DATA_W-1:0] srcM,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dstIdx,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx,
  output logic              writeEn,
  output logic              illegal,
  output logic [3:0]        flagsOut
);

  localparam int NUM_ROT = 1 << ROT_W;
  localparam int HALF_W  = DATA_W / 2;

  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotCand [NUM_ROT];
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   extended;
  logic [DATA_W-1:0]   sum;

  assign doubled = {srcM, srcM};

  // One candidate per rotate amount
  for (genvar k = 0; k < NUM_ROT; k++) begin : g_rot
    assign rotCand[k] = doubled[k*ROT_STEP +: DATA_W];
  end

  always_comb begin
    rotated  = rotCand[strb.rotSel];
    extended = {{HALF_W{rotated[HALF_W-1]}}, rotated[HALF_W-1:0]};
    sum      = srcN + extended;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      writeEn  <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
      dstIdx   <= '0;
      rnIdx    <= '0;
      rmIdx    <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= strb.capture;
      writeEn  <= strb.doWrite;
      illegal  <= strb.notOurs;
      if (strb.capture) begin
        result   <= sum;
        dstIdx   <= strb.dst;
        rnIdx    <= strb.srcA;
        rmIdx    <= strb.srcB;
        flagsOut <= flagsIn;
      end
    end
  end

endmodule

// File: rtl/rea_top.sv
module rea_top
  import rea_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ROT_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              isCompact,
  input  logic [INSN_W-1:0] instrWord,
  input  logic [3:0]        flagsIn,
  input  logic [DATA_W-1:0] srcN,
  input  logic [DATA_W-1:0] srcM,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dstIdx,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx,
  output logic              writeEn,
  output logic              illegal,
  output logic [3:0]        flagsOut
);

  reaStrobes_t strb;

  rea_ctrl ctrl_i (
    .inValid   (inValid),
    .isCompact (isCompact),
    .instrWord (instrWord),
    .flagsIn   (flagsIn),
    .strb      (strb)
  );

  rea_dpath #(
    .DATA_W   (DATA_W),
    .ROT_STEP (ROT_STEP)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .srcN     (srcN),
    .srcM     (srcM),
    .flagsIn  (flagsIn),
    .outValid (outValid),
    .result   (result),
    .dstIdx   (dstIdx),
    .rnIdx    (rnIdx),
    .rmIdx    (rmIdx),
    .writeEn  (writeEn),
    .illegal  (illegal),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/rea_chk.sv
module rea_chk
  import rea_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              isCompact,
  input logic [INSN_W-1:0] instrWord,
  input logic [3:0]        flagsIn,
  input logic              outValid,
  input logic              writeEn,
  input logic              illegal
);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !writeEn && !illegal));

  // R10
  exclusive_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(writeEn && illegal));

  // R11
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (writeEn || illegal) |-> outValid);

  // R9
  compact_always_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && isCompact && ((instrWord & CMP_MASK) == CMP_BASE)) |=> writeEn);

  // R8
  never_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isCompact && (instrWord[31:28] == 4'hF)) |=> (illegal && !writeEn));

  // R7
  always_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isCompact && ((instrWord & WORD_MASK) == WORD_BASE)
     && (instrWord[31:28] == 4'hE)) |=> writeEn);

  // R10
  bad_word_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isCompact && ((instrWord & WORD_MASK) != WORD_BASE)) |=> (illegal && !writeEn));

  // R7
  zflag_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isCompact && ((instrWord & WORD_MASK) == WORD_BASE)
     && (instrWord[31:28] == 4'h0) && !flagsIn[2]) |=> (!writeEn && !illegal));

endmodule

bind rea_top rea_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .isCompact (isCompact),
  .instrWord (instrWord),
  .flagsIn   (flagsIn),
  .outValid  (outValid),
  .writeEn   (writeEn),
  .illegal   (illegal)
);

// File: tb/rea_top_tb.sv
`timescale 1ns/1ps
module rea_top_tb_top;

  localparam real CLK_HALF = 4.0;
  localparam int  WATCHDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        isCompact;
  logic [31:0] instrWord;
  logic [3:0]  flagsIn;
  logic [31:0] srcN;
  logic [31:0] srcM;
  logic        outValid;
  logic [31:0] result;
  logic [3:0]  dstIdx, rnIdx, rmIdx;
  logic        writeEn;
  logic        illegal;
  logic [3:0]  flagsOut;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 0;

  always #(CLK_HALF) clk = ~clk;

  rea_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .isCompact (isCompact),
    .instrWord (instrWord),
    .flagsIn   (flagsIn),
    .srcN      (srcN),
    .srcM      (srcM),
    .outValid  (outValid),
    .result    (result),
    .dstIdx    (dstIdx),
    .rnIdx     (rnIdx),
    .rmIdx     (rmIdx),
    .writeEn   (writeEn),
    .illegal   (illegal),
    .flagsOut  (flagsOut)
  );

  // ---------------- reference model ----------------
  function automatic logic [31:0] refRor(logic [31:0] v, int unsigned amt);
    if (amt == 0) return v;
    return (v >> amt) | (v << (32 - amt));
  endfunction

  function automatic logic [31:0] refSum(logic [31:0] n, logic [31:0] m, logic [1:0] rot);
    logic [31:0] r;
    r = refRor(m, 8 * rot);
    return n + {{16{r[15]}}, r[15:0]};
  endfunction

  function automatic bit refCond(logic [3:0] code, logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] encWord(logic [3:0] cond, logic [3:0] rn, logic [3:0] rd,
                                          logic [1:0] rot, logic [3:0] rm);
    return {cond, 8'h6B, rn, rd, rot, 2'b00, 4'b0111, rm};
  endfunction

  function automatic logic [31:0] encCmp(logic [3:0] rn, logic [3:0] rd,
                                         logic [1:0] rot, logic [3:0] rm);
    return {12'hFA0, rn, 4'hF, rd, 2'b10, rot, rm};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Drive one instruction at a falling edge, check one cycle later
  task automatic runOne(string req, bit cmp, logic [31:0] insn, logic [3:0] fl,
                        logic [31:0] n, logic [31:0] m);
    logic [1:0] rot;
    logic [3:0] rd, rn, rm;
    bit match, exec;
    if (cmp) begin
      rot = insn[5:4]; rd = insn[11:8]; rn = insn[19:16]; rm = insn[3:0];
      match = ((insn & 32'hFFF0_F0C0) == 32'hFA00_F080);
      exec = 1;
    end else begin
      rot = insn[11:10]; rd = insn[15:12]; rn = insn[19:16]; rm = insn[3:0];
      match = ((insn & 32'h0FF0_03F0) == 32'h06B0_0070) && (insn[31:28] != 4'hF);
      exec = refCond(insn[31:28], fl);
    end
    inValid = 1'b1; isCompact = cmp; instrWord = insn; flagsIn = fl; srcN = n; srcM = m;
    @(negedge clk);
    inValid = 1'b0;
    check("R11", "outValid", {31'd0, outValid}, 32'd1);
    check(req, "writeEn", {31'd0, writeEn}, {31'd0, match && exec});
    check(req, "illegal", {31'd0, illegal}, {31'd0, !match});
    check("R3", "result", result, refSum(n, m, rot));
    check("R13", "dstIdx", {28'd0, dstIdx}, {28'd0, rd});
    check("R13", "rnIdx", {28'd0, rnIdx}, {28'd0, rn});
    check("R13", "rmIdx", {28'd0, rmIdx}, {28'd0, rm});
    check("R4", "flagsOut", {28'd0, flagsOut}, {28'd0, fl});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240917));
    rst = 1'b1; inValid = 1'b0; isCompact = 1'b0; instrWord = '0;
    flagsIn = '0; srcN = '0; srcM = '0;
    repeat (3) @(negedge clk);

    // R12: reset state
    check("R12", "outValid", {31'd0, outValid}, 32'd0);
    check("R12", "writeEn", {31'd0, writeEn}, 32'd0);
    check("R12", "illegal", {31'd0, illegal}, 32'd0);
    check("R12", "result", result, 32'd0);
    rst = 1'b0;

    // R1, R2: every rotation, both signs of the extracted halfword
    for (int r = 0; r < 4; r++) begin
      runOne("R1", 0, encWord(4'hE, 4'd1, 4'd2, r[1:0], 4'd3), 4'h0, 32'h0000_1000, 32'h89AB_CDEF);
      runOne("R2", 1, encCmp(4'd4, 4'd5, r[1:0], 4'd6), 4'h0, 32'h1111_1111, 32'h7F12_3456);
      runOne("R2", 0, encWord(4'hE, 4'd7, 4'd8, r[1:0], 4'd9), 4'hF, 32'h0, 32'h8000_8000);
    end

    // R3: wraparound on the add, flags unchanged on carry/overflow (R4)
    runOne("R3", 0, encWord(4'hE, 4'd0, 4'd1, 2'd0, 4'd2), 4'h0, 32'hFFFF_FFFF, 32'h0000_0001);
    runOne("R4", 1, encCmp(4'd0, 4'd1, 2'd0, 4'd2), 4'h0, 32'h7FFF_FFFF, 32'h0000_7FFF);
    runOne("R3", 0, encWord(4'hE, 4'd0, 4'd1, 2'd0, 4'd2), 4'hA, 32'h8000_0000, 32'h0000_8000);

    // R7, R8: each condition code with every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        runOne(c == 15 ? "R8" : "R7", 0, encWord(c[3:0], 4'd3, 4'd4, 2'd1, 4'd5), f[3:0],
               32'h1234_5678, 32'h0BAD_F00D);
      end
    end

    // R9: compact ignores flags
    for (int f = 0; f < 16; f++) begin
      runOne("R9", 1, encCmp(4'd9, 4'd10, 2'd3, 4'd11), f[3:0], 32'h0000_0005, 32'hFFFE_0000);
    end

    // R5, R6, R10: flip each fixed bit of each format
    for (int b = 0; b < 32; b++) begin
      if (32'h0FF0_03F0 & (32'd1 << b))
        runOne("R10", 0, encWord(4'hE, 4'd1, 4'd2, 2'd2, 4'd3) ^ (32'd1 << b), 4'h4, 32'd7, 32'd9);
      if (32'hFFF0_F0C0 & (32'd1 << b))
        runOne("R10", 1, encCmp(4'd1, 4'd2, 2'd2, 4'd3) ^ (32'd1 << b), 4'h4, 32'd7, 32'd9);
    end
    runOne("R5", 0, 32'h06B0_0070, 4'h0, 32'd100, 32'hFFFF_FF9C);
    runOne("R6", 1, 32'hFA00_F080, 4'h0, 32'd100, 32'hFFFF_FF9C);

    // R11: idle cycle holds data, clears strobes
    held = result;
    @(negedge clk);
    check("R11", "outValid idle", {31'd0, outValid}, 32'd0);
    check("R11", "writeEn idle", {31'd0, writeEn}, 32'd0);
    check("R11", "illegal idle", {31'd0, illegal}, 32'd0);
    check("R11", "result hold", result, held);

    // Constrained random mix
    for (int i = 0; i < 1500; i++) begin
      bit cmp;
      logic [31:0] insn;
      cmp = $urandom_range(0, 1);
      if (cmp) insn = encCmp($urandom, $urandom, $urandom, $urandom);
      else     insn = encWord($urandom, $urandom, $urandom, $urandom, $urandom);
      if ($urandom_range(0, 7) == 0) insn = insn ^ (32'd1 << $urandom_range(0, 31));
      runOne(cmp ? "R6" : "R5", cmp, insn, $urandom, $urandom, $urandom);
      if ($urandom_range(0, 9) == 0) @(negedge clk);
    end

    // R12: reset in the middle clears outputs
    runOne("R5", 0, encWord(4'hE, 4'd1, 4'd2, 2'd0, 4'd3), 4'h0, 32'd1, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "outValid after rst", {31'd0, outValid}, 32'd0);
    check("R12", "writeEn after rst", {31'd0, writeEn}, 32'd0);
    check("R12", "result after rst", result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    doneFlag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule